// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block carries out one multi-register transfer between a small register file and a full-descending stack in memory. A start pulse delivers the direction (store to the stack or load from it), a 16-bit mask naming the registers involved, and the current stack pointer. The block then works through the selected registers one word at a time over a simple request/ready memory port. When it finishes it pulses `done` and presents the updated stack pointer on `sp_out`.

Register numbers fix the layout. The smallest selected register always sits at the lowest stack address, and each later register sits one word above the previous one. A store (push) first moves the pointer down by the size of the whole list and then writes upward from there. A load (pop) reads upward from the pointer.

Some lists are illegal: an empty list, any list that names the stack pointer, a push that names the program counter, and a pop that names both the link register and the program counter. Such a list is rejected before any memory access, and no state is changed. When a pop loads the program counter, the loaded word must be odd. If it is, the block reports a branch to that word with bit 0 cleared. If it is not, the block raises a fault.

The register file model is reached from outside through a write port and a read port, and both work only while the block is idle.

Top module: `stack_seq`

## Requirements
- R1: A push of N registers (N = number of set mask bits) writes memory starting at address sp_in − 4·N. Each following access is 4 bytes higher. Registers are taken in increasing register number, so the lowest-numbered selected register lands at the lowest address. There is exactly one write per selected register.
- R2: A pop of N registers reads memory starting at sp_in, going upward in steps of 4. Registers are loaded in increasing register number, so the lowest-numbered register gets the lowest address. Registers not in the mask keep their value.
- R3: On completion, `sp_out` equals sp_in − 4·N after a push and sp_in + 4·N after a pop. A rejected request leaves `sp_out` unchanged. `sp_out` is 0 after reset.
- R4: A mask that is zero, or that has bit 13 (stack pointer) set, is rejected. The block raises `err` together with `done` in the cycle after the start edge. No memory access is made and no register is changed.
- R5: A push with mask bit 15 (program counter) set is rejected in the same way as R4. So is a pop with both bit 14 (link register) and bit 15 set. A push with bit 14 set is legal, and so is a pop with bit 15 set and bit 14 clear.
- R6: When a pop loads register 15 and the loaded word has bit 0 equal to 1, `branch_valid` pulses with `done`. `branch_target` then holds the word with bit 0 cleared, and register 15 takes that same value. If bit 0 is 0, `fault` pulses with `done`, `branch_valid` stays low, and register 15 is left unchanged.
- R7: `mem_req` is high only while a transfer runs. One access completes on each clock edge where `mem_req` and `mem_ready` are both high. While `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady. With S stalled cycles, `done` is high in the cycle after the (N+S)-th edge following the start edge. After reset, `busy`, `done` and `mem_req` are low.
- R8: A start pulse that arrives while the block is busy is ignored. The running transfer completes unchanged, and only one `done` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| op_pop | input | 1 | 1 = pop (load), 0 = push (store) |
| reg_mask | input | 16 | Register-select mask, bit i = register i |
| sp_in | input | 32 | Current stack pointer |
| rf_wr_en | input | 1 | External register write enable (idle only) |
| rf_wr_idx | input | 4 | External register write index |
| rf_wr_data | input | 32 | External register write data |
| rf_rd_idx | input | 4 | External register read index |
| rf_rd_data | output | 32 | External register read data (combinational) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal list, qualifies done |
| fault | output | 1 | Loaded program counter was even, qualifies done |
| branch_valid | output | 1 | Branch requested, qualifies done |
| branch_target | output | 32 | Halfword-aligned branch address |
| sp_out | output | 32 | Written-back stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |

## Verification
A rejected list shows its result one cycle after the start edge: `err` and `done` are visible at the first falling edge. A legal list of N registers with S stalled cycles completes its k-th access on the (S+k)-th rising edge after the start edge. Its `done`, `sp_out`, `branch_valid`, `fault` and `branch_target` are therefore visible at the (N+S+1)-th falling edge after the start was driven. The bench drives the start on a falling edge and counts falling edges until `done`. It compares that count with N+S+1, or with 1 for a rejected list, and reads the done-qualified flags in that same half cycle. It compares memory and register contents only afterwards, once they are stable.

// File: rtl/stack_seq_pkg.sv
`timescale 1ns/1ps
package stack_seq_pkg;
  localparam int SP_IDX     = 13;
  localparam int LR_IDX     = 14;
  localparam int PC_IDX     = 15;
  localparam int WORD_BYTES = 4;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/stack_seq_listchk.sv
`timescale 1ns/1ps
// Counts the selected registers and flags a list that may not be used.
module stack_seq_listchk
  import stack_seq_pkg::*;
#(
  parameter int NREG = 16,
  parameter int CW   = 5
) (
  input  logic            is_pop,
  input  logic [NREG-1:0] mask,
  output logic [CW-1:0]   count,
  output logic            illegal
);

  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) begin
      count = count + CW'(mask[i]);
    end
  end

  always_comb begin
    illegal = (mask == '0)
            | mask[SP_IDX]
            | (!is_pop & mask[PC_IDX])
            | (is_pop & mask[LR_IDX] & mask[PC_IDX]);
  end

endmodule

// File: rtl/stack_seq_pick.sv
`timescale 1ns/1ps
// Selects the lowest-numbered register still pending.
module stack_seq_pick #(
  parameter int NREG = 16,
  parameter int IW   = 4
) (
  input  logic [NREG-1:0] pending,
  output logic [NREG-1:0] onehot,
  output logic [IW-1:0]   idx,
  output logic            last
);

  always_comb begin
    onehot = pending & (~pending + NREG'(1));
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (onehot[i]) idx = IW'(i);
    end
  end

  always_comb begin
    last = ((pending & ~onehot) == '0);
  end

endmodule

// File: rtl/stack_seq_rf.sv
`timescale 1ns/1ps
// Register file model: one sequencer port, one external port (sequencer wins).
module stack_seq_rf #(
  parameter int NREG = 16,
  parameter int IW   = 4,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [IW-1:0] host_widx,
  input  logic [DW-1:0] host_wdata,
  input  logic [IW-1:0] host_ridx,
  output logic [DW-1:0] host_rdata,
  input  logic          seq_we,
  input  logic [IW-1:0] seq_idx,
  input  logic [DW-1:0] seq_wdata,
  output logic [DW-1:0] seq_rdata
);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          seq_hit;
    logic          en;
    logic [DW-1:0] d;
    logic [DW-1:0] q;

    always_comb begin
      seq_hit = seq_we && (seq_idx == IW'(g));
      en      = seq_hit || (host_we && (host_widx == IW'(g)));
      d       = seq_hit ? seq_wdata : host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign regs[g] = q;
  end

  assign host_rdata = regs[host_ridx];
  assign seq_rdata  = regs[seq_idx];

endmodule

// File: rtl/stack_seq.sv
`timescale 1ns/1ps
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG),
  parameter int DW   = 32,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_pop,
  input  logic [NREG-1:0] reg_mask,
  input  logic [AW-1:0]   sp_in,
  input  logic            rf_wr_en,
  input  logic [IW-1:0]   rf_wr_idx,
  input  logic [DW-1:0]   rf_wr_data,
  input  logic [IW-1:0]   rf_rd_idx,
  output logic [DW-1:0]   rf_rd_data,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            fault,
  output logic            branch_valid,
  output logic [DW-1:0]   branch_target,
  output logic [AW-1:0]   sp_out,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready
);

  localparam int CW = $clog2(NREG + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  seq_state_e      state_q, state_d;
  logic [NREG-1:0] pend_q, pend_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [AW-1:0]   fsp_q, fsp_d;
  logic [AW-1:0]   spo_q, spo_d;
  logic [DW-1:0]   tgt_q, tgt_d;
  logic            pop_q, pop_d;
  logic            done_q, done_d;
  logic            err_q, err_d;
  logic            fault_q, fault_d;
  logic            brv_q, brv_d;

  logic [CW-1:0]   cnt;
  logic            illegal;
  logic [NREG-1:0] onehot;
  logic [IW-1:0]   idx;
  logic            last;
  logic [AW-1:0]   span;
  logic            accept, step, pc_hit, pc_odd;
  logic            seq_we;
  logic [DW-1:0]   seq_wdata, seq_rdata, pc_clr;

  stack_seq_listchk #(.NREG(NREG), .CW(CW)) u_listchk (
    .is_pop  (op_pop),
    .mask    (reg_mask),
    .count   (cnt),
    .illegal (illegal)
  );

  stack_seq_pick #(.NREG(NREG), .IW(IW)) u_pick (
    .pending (pend_q),
    .onehot  (onehot),
    .idx     (idx),
    .last    (last)
  );

  stack_seq_rf #(.NREG(NREG), .IW(IW), .DW(DW)) u_rf (
    .clk        (clk),
    .rst_n      (rst_s),
    .host_we    (rf_wr_en && (state_q == ST_IDLE)),
    .host_widx  (rf_wr_idx),
    .host_wdata (rf_wr_data),
    .host_ridx  (rf_rd_idx),
    .host_rdata (rf_rd_data),
    .seq_we     (seq_we),
    .seq_idx    (idx),
    .seq_wdata  (seq_wdata),
    .seq_rdata  (seq_rdata)
  );

  always_comb begin
    span   = {{(AW-CW-2){1'b0}}, cnt, 2'b00};
    accept = (state_q == ST_IDLE) && start;
    step   = (state_q == ST_RUN) && mem_ready;
    pc_hit = pop_q && (idx == IW'(PC_IDX));
    pc_odd = mem_rdata[0];
    pc_clr = {mem_rdata[DW-1:1], 1'b0};
  end

  // loads write the register file; an even program-counter word is dropped
  always_comb begin
    seq_we    = step && pop_q && !(pc_hit && !pc_odd);
    seq_wdata = pc_hit ? pc_clr : mem_rdata;
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    addr_d  = addr_q;
    fsp_d   = fsp_q;
    spo_d   = spo_q;
    tgt_d   = tgt_q;
    pop_d   = pop_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    fault_d = 1'b0;
    brv_d   = 1'b0;
    if (accept) begin
      if (illegal) begin
        done_d = 1'b1;
        err_d  = 1'b1;
      end else begin
        state_d = ST_RUN;
        pend_d  = reg_mask;
        pop_d   = op_pop;
        addr_d  = op_pop ? sp_in : (sp_in - span);
        fsp_d   = op_pop ? (sp_in + span) : (sp_in - span);
      end
    end else if (step) begin
      pend_d = pend_q & ~onehot;
      addr_d = addr_q + AW'(WORD_BYTES);
      if (pc_hit && pc_odd) tgt_d = pc_clr;
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        spo_d   = fsp_q;
        brv_d   = pc_hit && pc_odd;
        fault_d = pc_hit && !pc_odd;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      fsp_q   <= '0;
      spo_q   <= '0;
      tgt_q   <= '0;
      pop_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      fault_q <= 1'b0;
      brv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      fault_q <= fault_d;
      brv_q   <= brv_d;
      if (accept || step) begin
        pend_q <= pend_d;
        addr_q <= addr_d;
        tgt_q  <= tgt_d;
        spo_q  <= spo_d;
      end
      if (accept) begin
        fsp_q <= fsp_d;
        pop_q <= pop_d;
      end
    end
  end

  assign busy          = (state_q == ST_RUN);
  assign done          = done_q;
  assign err           = err_q;
  assign fault         = fault_q;
  assign branch_valid  = brv_q;
  assign branch_target = tgt_q;
  assign sp_out        = spo_q;
  assign mem_req       = (state_q == ST_RUN);
  assign mem_we        = (state_q == ST_RUN) && !pop_q;
  assign mem_addr      = addr_q;
  assign mem_wdata     = seq_rdata;

  // R1: consecutive accesses of one transfer climb by one word
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + AW'(WORD_BYTES))));

  // R4: an empty list or one naming the stack pointer is refused next cycle
  a_r4_bad_list: assert property (@(posedge clk) disable iff (!rst_s)
    (start && !busy && ((reg_mask == '0) || reg_mask[SP_IDX])) |=> (err && done));

  // R4: a refusal is never preceded by a memory access
  a_r4_no_access: assert property (@(posedge clk) disable iff (!rst_s)
    err |-> !$past(mem_req));

  // R5: a push naming the program counter is refused
  a_r5_push_pc: assert property (@(posedge clk) disable iff (!rst_s)
    (start && !busy && !op_pop && reg_mask[PC_IDX]) |=> err);

  // R6: a branch comes only with a clean completion and an even target
  a_r6_branch_ok: assert property (@(posedge clk) disable iff (!rst_s)
    branch_valid |-> (done && !err && !fault && !branch_target[0]));

  // R7: a stalled request keeps its address, direction and data
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: tb/stack_seq_bench.sv
`timescale 1ns/1ps
module stack_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, op_pop;
  logic [15:0] reg_mask;
  logic [31:0] sp_in;
  logic        rf_wr_en;
  logic [3:0]  rf_wr_idx, rf_rd_idx;
  logic [31:0] rf_wr_data, rf_rd_data;
  logic        busy, done, err, fault, branch_valid;
  logic [31:0] branch_target, sp_out;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [64];
  logic [3:0]  stall_left, stall_cfg;
  logic        stall_load, init_go, poke_go;
  logic [5:0]  poke_idx;
  logic [31:0] poke_val;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  stack_seq u_stack_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_pop(op_pop),
    .reg_mask(reg_mask), .sp_in(sp_in),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .busy(busy), .done(done), .err(err), .fault(fault),
    .branch_valid(branch_valid), .branch_target(branch_target), .sp_out(sp_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  function automatic logic [31:0] mpat(input int k);
    return 32'h1357_0001 + 32'(k << 8);
  endfunction

  function automatic logic [31:0] rval(input int i);
    return 32'hA0A0_0000 + 32'(i * 17);
  endfunction

  // memory model with a programmable number of stalled cycles
  assign mem_rdata = mem[mem_addr[7:2]];
  assign mem_ready = (stall_left == 4'd0);

  always @(posedge clk) begin
    if (init_go) begin
      for (int k = 0; k < 64; k++) mem[k] <= mpat(k);
    end else if (poke_go) begin
      mem[poke_idx] <= poke_val;
    end else if (mem_req && mem_we && mem_ready) begin
      mem[mem_addr[7:2]] <= mem_wdata;
    end
    if (!rst_n)                          stall_left <= 4'd0;
    else if (stall_load)                 stall_left <= stall_cfg;
    else if (mem_req && stall_left != 0) stall_left <= stall_left - 4'd1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input int i, output logic [31:0] v);
    rf_rd_idx = 4'(i);
    #0.2;
    v = rf_rd_data;
  endtask

  // fill memory with a pattern and every register with rval(i)
  task automatic prep();
    @(negedge clk);
    init_go = 1'b1;
    @(negedge clk);
    init_go = 1'b0;
    for (int i = 0; i < 16; i++) begin
      rf_wr_en = 1'b1; rf_wr_idx = 4'(i); rf_wr_data = rval(i);
      @(negedge clk);
    end
    rf_wr_en = 1'b0;
  endtask

  task automatic run_op(input logic op, input logic [15:0] m, input logic [31:0] sp,
                        input logic [3:0] st, output int cyc);
    @(negedge clk);
    op_pop = op; reg_mask = m; sp_in = sp; start = 1'b1;
    stall_cfg = st; stall_load = 1'b1;
    @(negedge clk);
    start = 1'b0; stall_load = 1'b0; cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // {op, mask, sp, stall, expect_err}
  localparam int NV = 9;
  localparam logic [53:0] VEC [NV] = '{
    {1'b0, 16'h00F1, 32'h0000_0080, 4'd0, 1'b0},  // R1 push r0,r4-r7
    {1'b0, 16'h4004, 32'h0000_00A0, 4'd2, 1'b0},  // R1 R5 push r2,lr with stall
    {1'b1, 16'h00F1, 32'h0000_0070, 4'd0, 1'b0},  // R2 pop r0,r4-r7
    {1'b1, 16'h8401, 32'h0000_0040, 4'd3, 1'b0},  // R2 R5 R6 pop r0,r10,pc
    {1'b0, 16'h0000, 32'h0000_0080, 4'd0, 1'b1},  // R4 empty
    {1'b0, 16'h2001, 32'h0000_0080, 4'd0, 1'b1},  // R4 sp in list
    {1'b1, 16'h2000, 32'h0000_0040, 4'd0, 1'b1},  // R4 pop sp
    {1'b0, 16'h8001, 32'h0000_0080, 4'd0, 1'b1},  // R5 push pc
    {1'b1, 16'hC000, 32'h0000_0040, 4'd0, 1'b1}   // R5 pop lr+pc
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, prev_sp, base, exp_tgt;
    int cyc, n, k, w, dcount, dfirst;
    logic f_err, f_fault, f_brv;
    logic [31:0] f_tgt;

    rst_n = 1'b0; start = 1'b0; op_pop = 1'b0; reg_mask = '0; sp_in = '0;
    rf_wr_en = 1'b0; rf_wr_idx = '0; rf_wr_data = '0; rf_rd_idx = '0;
    stall_cfg = '0; stall_load = 1'b0; init_go = 1'b0; poke_go = 1'b0;
    poke_idx = '0; poke_val = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk("R7 reset busy", 32'(busy), 32'd0);
    chk("R7 reset mem_req", 32'(mem_req), 32'd0);
    chk("R7 reset done", 32'(done), 32'd0);
    chk("R3 reset sp_out", sp_out, 32'd0);

    for (int vi = 0; vi < NV; vi++) begin
      logic        op;
      logic [15:0] m;
      logic [31:0] sp;
      logic [3:0]  st;
      logic        xe;
      {op, m, sp, st, xe} = VEC[vi];
      prep();
      prev_sp = sp_out;
      run_op(op, m, sp, st, cyc);
      f_err = err; f_fault = fault; f_brv = branch_valid; f_tgt = branch_target;
      n = $countones(m);
      chk("R4_R5 err flag", 32'(f_err), 32'(xe));
      if (xe) begin
        chk("R4_R5 reject latency", 32'(cyc), 32'd1);
        chk("R4 sp_out kept", sp_out, prev_sp);
        w = ((sp >> 2) - 1) & 63;
        chk("R4 memory untouched", mem[w], mpat(w));
        rd_reg(0, v);
        chk("R4 register untouched", v, rval(0));
      end else begin
        chk("R7 completion latency", 32'(cyc), 32'(n + st + 1));
        chk("R3 sp writeback", sp_out, op ? sp + 32'(4*n) : sp - 32'(4*n));
        base = op ? sp : sp - 32'(4*n);
        k = 0;
        for (int i = 0; i < 16; i++) begin
          if (m[i]) begin
            w = ((base >> 2) + k) & 63;
            if (!op) begin
              chk("R1 pushed word", mem[w], rval(i));
            end else if (i == 15) begin
              exp_tgt = mpat(w) & ~32'd1;
              chk("R6 branch_valid", 32'(f_brv), 32'd1);
              chk("R6 fault low", 32'(f_fault), 32'd0);
              chk("R6 branch_target", f_tgt, exp_tgt);
              rd_reg(15, v);
              chk("R6 pc register", v, exp_tgt);
            end else begin
              rd_reg(i, v);
              chk("R2 popped register", v, mpat(w));
            end
            k++;
          end
        end
        if (op && !m[1]) begin
          rd_reg(1, v);
          chk("R2 unselected register kept", v, rval(1));
        end
      end
    end

    // R6: even program-counter word gives a fault
    prep();
    @(negedge clk);
    poke_go = 1'b1; poke_idx = 6'd8; poke_val = 32'h0000_0246;
    @(negedge clk);
    poke_go = 1'b0;
    run_op(1'b1, 16'h8000, 32'h0000_0020, 4'd1, cyc);
    f_fault = fault; f_brv = branch_valid; f_err = err;
    chk("R6 fault raised", 32'(f_fault), 32'd1);
    chk("R6 no branch on fault", 32'(f_brv), 32'd0);
    chk("R6 fault latency", 32'(cyc), 32'd3);
    chk("R3 sp after faulting pop", sp_out, 32'h0000_0024);
    rd_reg(15, v);
    chk("R6 pc kept on fault", v, rval(15));

    // R8: a second start during a running push is ignored
    prep();
    @(negedge clk);
    op_pop = 1'b0; reg_mask = 16'h0003; sp_in = 32'h0000_0060; start = 1'b1;
    stall_cfg = 4'd3; stall_load = 1'b1;
    @(negedge clk);
    start = 1'b0; stall_load = 1'b0;
    dcount = 0; dfirst = 0;
    for (int c = 1; c <= 12; c++) begin
      if (c == 2) begin
        op_pop = 1'b1; reg_mask = 16'h0001; sp_in = 32'h0000_0010; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) begin
        dcount++;
        if (dfirst == 0) dfirst = c;
      end
      @(negedge clk);
    end
    chk("R8 single done", 32'(dcount), 32'd1);
    chk("R8 done timing", 32'(dfirst), 32'd6);
    chk("R8 sp from first op", sp_out, 32'h0000_0058);
    chk("R8 first word", mem[22], rval(0));
    chk("R8 second word", mem[23], rval(1));
    rd_reg(0, v);
    chk("R8 ignored pop left r0", v, rval(0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule